// File: doc/BRIEF.md
# Cascaded Interrupt Vector Acknowledge Unit

This unit pairs two eight-line request resolvers, a primary and a secondary, into one controller that serves fifteen sources. Sources 0 to 7 land on the primary lines, and sources 8 to 15 land on the secondary lines. Source bit 3 picks the controller and bits 2:0 pick the line. Primary line 2 takes no external source. It is driven instead by the secondary: every cycle in which the secondary holds a pending request, that line receives a fresh edge event.

A CPU sees one interrupt line, which shows whether the primary has anything pending. To take an interrupt, the CPU raises an acknowledge strobe. The unit then resolves the primary winner. When that winner is the cascade line, it also resolves the secondary winner. It clears the served edge-mode requests and returns an 8-bit vector, formed from the base of the controller that supplied the line with that line number in the low three bits. When no real source is behind the acknowledge, the unit returns a spurious vector. A small trigger-mode register per controller selects edge or level sensing for each line. Some of its bits are fixed to edge.

Top module: `casc_vec_ack`

## Requirements
- R1: After reset, int_o, vec_vld_o, vec_o, tm_m_o and tm_s_o are all zero. All pending requests are cleared and every line senses edges.
- R2: Source n with n in 0..7 maps to primary line n, and source n with n in 8..15 maps to secondary line n-8. A served vector is the controller base with its low 3 bits forced to zero, OR-ed with the 3-bit line number.
- R3: Within a controller the pending line with the smallest number wins. The primary winner is always resolved before the secondary.
- R4: An edge-mode line latches a request on a 0-to-1 transition of its input. The request stays pending after the input falls, until an acknowledge serves it, and the acknowledge clears it.
- R5: A level-mode line (trigger bit = 1) is pending exactly while its input was high at the last clock edge. An acknowledge does not clear it.
- R6: A trigger-mode write takes tm_wdata_i AND 0xF8 for the primary (tm_sel_i = 0) or AND 0xDE for the secondary (tm_sel_i = 1). It shows on tm_m_o or tm_s_o after the clock edge.
- R7: Source 2 (irq_i[2]) is ignored. Primary line 2 becomes pending at the same edge as any request becomes pending on the secondary, and again at every edge while one stays pending.
- R8: When the primary winner at acknowledge is line 2 and the secondary has a winner, the vector comes from the secondary base and the secondary line. Both the served lines are cleared if they are edge-mode.
- R9: If the primary has nothing pending at acknowledge, the vector is primary base | 7 and no request is cleared.
- R10: If the primary winner is line 2 but the secondary has nothing pending, the vector is secondary base | 7 and primary line 2 is cleared.
- R11: int_o is high exactly when at least one primary line is pending. It follows every state update.
- R12: A high ack_i seen while idle is served at that edge, and vec_vld_o rises one cycle later. vec_o holds while vec_vld_o is high. vec_vld_o drops at the first edge at which ack_i is low, and no new acknowledge is taken before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Source request inputs; bit 2 is unused |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| m_base_i | input | 8 | Primary vector base (low 3 bits ignored) |
| s_base_i | input | 8 | Secondary vector base (low 3 bits ignored) |
| tm_we_i | input | 1 | Trigger-mode register write enable |
| tm_sel_i | input | 1 | Trigger-mode target: 0 primary, 1 secondary |
| tm_wdata_i | input | 8 | Trigger-mode write data, 1 = level |
| vec_o | output | 8 | Served interrupt vector |
| vec_vld_o | output | 1 | Vector valid, held until ack_i drops |
| int_o | output | 1 | Interrupt request to the CPU |
| tm_m_o | output | 8 | Primary trigger-mode register |
| tm_s_o | output | 8 | Secondary trigger-mode register |

## Verification
The spurious-vector property assumes that m_base_i does not change in the cycle of an acknowledge. The stability property assumes that each acknowledge is a level held until vec_vld_o is seen. The stimulus programs both bases once before any acknowledge. It raises ack_i only from idle and drops it only after the vector has been read. Requests, trigger-mode writes and acknowledges may share a cycle. The cascade properties rely only on the secondary being pending, whatever the source order.

// File: rtl/casc_pkg.sv
package casc_pkg;
  localparam int unsigned LINES      = 8;
  localparam int unsigned LW         = $clog2(LINES);
  localparam int unsigned VW         = 8;
  localparam int unsigned NSRC       = 2 * LINES;
  localparam int unsigned CASC_LINE  = 2;
  localparam logic [LINES-1:0] M_TM_MASK = 8'hF8;
  localparam logic [LINES-1:0] S_TM_MASK = 8'hDE;

  typedef enum logic {ACK_IDLE, ACK_HOLD} ack_st_e;
endpackage

// File: rtl/casc_tm_reg.sv
module casc_tm_reg #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] tm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tm_o <= '0;
    else if (we_i) tm_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/casc_line_core.sv
module casc_line_core #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  tm_i,
  input  logic [N-1:0]  clr_i,
  output logic [N-1:0]  irr_o,
  output logic [N-1:0]  irr_nxt_o,
  output logic          win_vld_o,
  output logic [LW-1:0] win_idx_o
);
  logic [N-1:0] last_q;

  // level lines mirror input; edge lines latch rise, clear on service
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (tm_i[i]) irr_nxt_o[i] = req_i[i];
      else         irr_nxt_o[i] = (irr_o[i] & ~clr_i[i]) | (req_i[i] & ~last_q[i]) | set_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_o  <= '0;
      last_q <= '0;
    end else begin
      irr_o  <= irr_nxt_o;
      last_q <= req_i;
    end
  end

  // fixed priority, line 0 highest
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (irr_o[i]) begin
        win_vld_o = 1'b1;
        win_idx_o = LW'(i);
      end
    end
  end
endmodule

// File: rtl/casc_ack_seq.sv
module casc_ack_seq
  import casc_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter int unsigned LW   = $clog2(N),
  parameter int unsigned VW   = 8,
  parameter int unsigned CASC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_i,
  input  logic          m_vld_i,
  input  logic [LW-1:0] m_idx_i,
  input  logic          s_vld_i,
  input  logic [LW-1:0] s_idx_i,
  input  logic [VW-1:0] m_base_i,
  input  logic [VW-1:0] s_base_i,
  output logic [N-1:0]  m_clr_o,
  output logic [N-1:0]  s_clr_o,
  output logic [VW-1:0] vec_o,
  output logic          vld_o
);
  localparam logic [VW-1:0] LOW_ONES  = VW'((1 << LW) - 1);
  localparam logic [VW-1:0] BASE_MASK = ~LOW_ONES;

  ack_st_e       st_q;
  logic          take;
  logic [VW-1:0] vec_d;

  assign take  = (st_q == ACK_IDLE) && ack_i;
  assign vld_o = (st_q == ACK_HOLD);

  always_comb begin
    m_clr_o = '0;
    s_clr_o = '0;
    if (!m_vld_i) begin
      vec_d = (m_base_i & BASE_MASK) | LOW_ONES;
    end else if (m_idx_i == LW'(CASC)) begin
      m_clr_o[CASC] = take;
      if (s_vld_i) begin
        s_clr_o[s_idx_i] = take;
        vec_d = (s_base_i & BASE_MASK) | VW'(s_idx_i);
      end else begin
        vec_d = (s_base_i & BASE_MASK) | LOW_ONES;
      end
    end else begin
      m_clr_o[m_idx_i] = take;
      vec_d = (m_base_i & BASE_MASK) | VW'(m_idx_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ACK_IDLE;
      vec_o <= '0;
    end else begin
      case (st_q)
        ACK_IDLE: if (ack_i) begin
          st_q  <= ACK_HOLD;
          vec_o <= vec_d;
        end
        default: if (!ack_i) st_q <= ACK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/casc_vec_ack.sv
module casc_vec_ack
  import casc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] irq_i,
  input  logic            ack_i,
  input  logic [VW-1:0]   m_base_i,
  input  logic [VW-1:0]   s_base_i,
  input  logic            tm_we_i,
  input  logic            tm_sel_i,
  input  logic [LINES-1:0] tm_wdata_i,
  output logic [VW-1:0]   vec_o,
  output logic            vec_vld_o,
  output logic            int_o,
  output logic [LINES-1:0] tm_m_o,
  output logic [LINES-1:0] tm_s_o
);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC_LINE;

  logic [1:0][LINES-1:0] tm_q;
  logic [LINES-1:0] m_req, m_set, m_clr, m_irr, m_nxt;
  logic [LINES-1:0] s_req, s_clr, s_irr, s_nxt;
  logic             m_vld, s_vld;
  logic [LW-1:0]    m_idx, s_idx;

  for (genvar c = 0; c < 2; c++) begin : g_tm
    casc_tm_reg #(
      .N    (LINES),
      .MASK (c == 0 ? M_TM_MASK : S_TM_MASK)
    ) u_tm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (tm_we_i && (tm_sel_i == 1'(c))),
      .wdata_i (tm_wdata_i),
      .tm_o    (tm_q[c])
    );
  end

  assign tm_m_o = tm_q[0];
  assign tm_s_o = tm_q[1];

  assign m_req = irq_i[LINES-1:0] & ~CASC_BIT;
  assign s_req = irq_i[NSRC-1:LINES];
  // cascade: rise+fall each update, so line re-arms while secondary pends
  assign m_set = (|s_nxt) ? CASC_BIT : '0;

  casc_line_core #(.N(LINES), .LW(LW)) u_sec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (s_req),
    .set_i     ('0),
    .tm_i      (tm_q[1]),
    .clr_i     (s_clr),
    .irr_o     (s_irr),
    .irr_nxt_o (s_nxt),
    .win_vld_o (s_vld),
    .win_idx_o (s_idx)
  );

  casc_line_core #(.N(LINES), .LW(LW)) u_pri (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (m_req),
    .set_i     (m_set),
    .tm_i      (tm_q[0]),
    .clr_i     (m_clr),
    .irr_o     (m_irr),
    .irr_nxt_o (m_nxt),
    .win_vld_o (m_vld),
    .win_idx_o (m_idx)
  );

  casc_ack_seq #(.N(LINES), .LW(LW), .VW(VW), .CASC(CASC_LINE)) u_ack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ack_i    (ack_i),
    .m_vld_i  (m_vld),
    .m_idx_i  (m_idx),
    .s_vld_i  (s_vld),
    .s_idx_i  (s_idx),
    .m_base_i (m_base_i),
    .s_base_i (s_base_i),
    .m_clr_o  (m_clr),
    .s_clr_o  (s_clr),
    .vec_o    (vec_o),
    .vld_o    (vec_vld_o)
  );

  assign int_o = m_vld;
endmodule

// File: rtl/casc_vec_ack_chk.sv
module casc_vec_ack_chk
  import casc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic [VW-1:0]    m_base_i,
  input logic             tm_we_i,
  input logic             tm_sel_i,
  input logic [LINES-1:0] tm_wdata_i,
  input logic [VW-1:0]    vec_o,
  input logic             vec_vld_o,
  input logic             int_o,
  input logic [LINES-1:0] tm_m_o,
  input logic [LINES-1:0] tm_s_o,
  input logic [LINES-1:0] m_irr,
  input logic [LINES-1:0] m_nxt,
  input logic [LINES-1:0] s_irr,
  input logic [LINES-1:0] s_nxt
);
  a_r12_vec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o && $past(vec_vld_o) |-> $stable(vec_o));

  a_r12_rise_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_vld_o) |-> $past(ack_i));

  a_r12_held_while_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o && ack_i |=> vec_vld_o);

  a_r6_pri_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tm_we_i && !tm_sel_i |=> tm_m_o == ($past(tm_wdata_i) & M_TM_MASK));

  a_r6_sec_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tm_we_i && tm_sel_i |=> tm_s_o == ($past(tm_wdata_i) & S_TM_MASK));

  a_r7_cascade_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_irr[CASC_LINE]) |-> (s_irr != '0));

  a_r7_cascade_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_nxt != '0) |-> m_nxt[CASC_LINE]);

  a_r11_int_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o == (|m_irr));

  a_r9_spurious_pri: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_vld_o) && !$past(int_o) |->
      (vec_o[LW-1:0] == '1) && (vec_o[VW-1:LW] == $past(m_base_i[VW-1:LW])));
endmodule

bind casc_vec_ack casc_vec_ack_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .m_base_i   (m_base_i),
  .tm_we_i    (tm_we_i),
  .tm_sel_i   (tm_sel_i),
  .tm_wdata_i (tm_wdata_i),
  .vec_o      (vec_o),
  .vec_vld_o  (vec_vld_o),
  .int_o      (int_o),
  .tm_m_o     (tm_m_o),
  .tm_s_o     (tm_s_o),
  .m_irr      (m_irr),
  .m_nxt      (m_nxt),
  .s_irr      (s_irr),
  .s_nxt      (s_nxt)
);

// File: tb/casc_vec_ack_bench.sv
module casc_vec_ack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        ack = 1'b0;
  logic [7:0]  mbase = 8'h23;
  logic [7:0]  sbase = 8'h70;
  logic        tm_we = 1'b0;
  logic        tm_sel = 1'b0;
  logic [7:0]  tm_wd = '0;
  logic [7:0]  vec;
  logic        vld, intr;
  logic [7:0]  tm_m, tm_s;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  casc_vec_ack u_casc_vec_ack (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ack_i(ack),
    .m_base_i(mbase), .s_base_i(sbase),
    .tm_we_i(tm_we), .tm_sel_i(tm_sel), .tm_wdata_i(tm_wd),
    .vec_o(vec), .vec_vld_o(vld), .int_o(intr),
    .tm_m_o(tm_m), .tm_s_o(tm_s)
  );

  // reference model
  logic [7:0] r_mirr, r_sirr, r_mlast, r_slast, r_mtm, r_stm, r_vec;
  logic       r_vld;

  function automatic int first_set(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int mw, sw;
    logic [7:0] mclr, sclr, mn, sn, mreq;
    if (!rst_n) begin
      r_mirr = 0; r_sirr = 0; r_mlast = 0; r_slast = 0;
      r_mtm = 0; r_stm = 0; r_vec = 0; r_vld = 0;
    end else begin
      mw = first_set(r_mirr);
      sw = first_set(r_sirr);
      mclr = 0; sclr = 0;
      if (!r_vld && ack) begin
        r_vld = 1;
        if (mw < 0) r_vec = {mbase[7:3], 3'd7};
        else if (mw == 2) begin
          mclr[2] = 1;
          if (sw < 0) r_vec = {sbase[7:3], 3'd7};
          else begin sclr[sw] = 1; r_vec = {sbase[7:3], 3'(sw)}; end
        end else begin
          mclr[mw] = 1; r_vec = {mbase[7:3], 3'(mw)};
        end
      end else if (r_vld && !ack) r_vld = 0;
      for (int i = 0; i < 8; i++)
        sn[i] = r_stm[i] ? irq[8+i] : ((r_sirr[i] & ~sclr[i]) | (irq[8+i] & ~r_slast[i]));
      mreq = irq[7:0];
      mreq[2] = 1'b0;
      for (int i = 0; i < 8; i++)
        mn[i] = r_mtm[i] ? mreq[i] : ((r_mirr[i] & ~mclr[i]) | (mreq[i] & ~r_mlast[i]));
      if (sn != 0) mn[2] = 1'b1;
      r_mlast = mreq; r_slast = irq[15:8];
      r_mirr = mn; r_sirr = sn;
      if (tm_we) begin
        if (tm_sel) r_stm = tm_wd & 8'hDE;
        else        r_mtm = tm_wd & 8'hF8;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 int_o", intr, (r_mirr != 0));
      chk("R12 vec_vld_o", vld, r_vld);
      chk("R2 vec_o", vec, r_vec);
      chk("R6 tm_m_o", tm_m, r_mtm);
      chk("R6 tm_s_o", tm_s, r_stm);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(input string tag, input logic [7:0] exp);
    @(negedge clk) ack = 1'b1;
    @(negedge clk);
    chk({tag, " valid"}, vld, 1);
    chk({tag, " vector"}, vec, exp);
    ack = 1'b0;
    @(negedge clk);
    chk("R12 valid drops", vld, 0);
  endtask

  task automatic tm_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    tm_we = 1'b1; tm_sel = sel; tm_wd = d;
    @(negedge clk);
    tm_we = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] bits);
    @(negedge clk) irq = irq | bits;
    @(negedge clk) irq = irq & ~bits;
  endtask

  initial begin : wdog
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    step(2);
    #1 rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 int_o", intr, 0);
    chk("R1 vec_vld_o", vld, 0);
    chk("R1 vec_o", vec, 0);
    chk("R1 tm", {tm_m, tm_s}, 0);

    // R4 edge latch held after input falls
    pulse(16'h0020);
    step(3);
    chk("R4 held pending", intr, 1);
    do_ack("R2 R4 line5", 8'h25);
    chk("R4 cleared by ack", intr, 0);

    // R3 priority, then R9 spurious primary
    pulse(16'h004A);
    step(1);
    do_ack("R3 first", 8'h21);
    do_ack("R3 second", 8'h23);
    do_ack("R3 third", 8'h26);
    chk("R9 nothing pending", intr, 0);
    do_ack("R9 spurious primary", 8'h27);

    // R7 source 2 ignored
    pulse(16'h0004);
    step(2);
    chk("R7 source2 ignored", intr, 0);

    // R7 cascade raises line 2, R8 secondary vector
    pulse(16'h1000);
    chk("R7 cascade int", intr, 1);
    do_ack("R8 secondary line4", 8'h74);
    chk("R8 cleared", intr, 0);

    // R3 primary before cascade
    pulse(16'h1002);
    do_ack("R3 primary line1 first", 8'h21);
    do_ack("R8 then secondary", 8'h74);

    // R6 masks
    tm_write(1'b0, 8'hFF);
    chk("R6 primary mask", tm_m, 8'hF8);
    tm_write(1'b1, 8'hFF);
    chk("R6 secondary mask", tm_s, 8'hDE);
    tm_write(1'b0, 8'h10);
    tm_write(1'b1, 8'h02);

    // R5 level line not cleared by ack
    @(negedge clk) irq[4] = 1'b1;
    step(1);
    do_ack("R5 level line4", 8'h24);
    chk("R5 still pending", intr, 1);
    irq[4] = 1'b0;
    step(1);
    chk("R5 drops with input", intr, 0);

    // R10 spurious secondary: level source drops before ack
    @(negedge clk) irq[9] = 1'b1;
    step(2);
    irq[9] = 1'b0;
    step(2);
    chk("R10 line2 still pending", intr, 1);
    do_ack("R10 spurious secondary", 8'h77);
    chk("R10 line2 cleared", intr, 0);

    // R12 ack held long: one vector only
    pulse(16'h0080);
    @(negedge clk) ack = 1'b1;
    step(4);
    chk("R12 held valid", vld, 1);
    chk("R12 held vector", vec, 8'h27);
    ack = 1'b0;
    step(1);
    chk("R12 released", vld, 0);
    step(2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule